// File: doc/BRIEF.md
# Real-Time Clock with Maskable Event Interrupts

This block keeps wall-clock time as a chain of counters (seconds, minutes, hours and a day count) that advance once per pulse of a synchronous 1 Hz tick enable. The whole time is packed into one 32-bit word that software reads and writes over a small register bus. A countdown stopwatch register and an alarm match register sit next to the time counters. Six event sources feed a set of sticky pending flags: seconds, minutes, hours, midnight, stopwatch expiry and alarm match.

An enable register masks each source on its own. The level interrupt output is high while any pending flag has its enable set. The wake-up output pulses for one cycle whenever an enabled event occurs. The stopwatch runs under a two-state machine. In state SW_IDLE the count is zero and ticks are ignored. A write of a nonzero value moves it to SW_RUN. In SW_RUN each tick decrements the count. The tick that takes the count from 1 to 0 raises the expiry event and returns to SW_IDLE. Writing zero while in SW_RUN also returns to SW_IDLE, and raises no event.

Top module: `rtc_core`

## Requirements
- R1: After reset the enable register and all pending flags are zero, the stopwatch is zero, the alarm register holds all ones, and both irq and wake are low.
- R2: Each tick advances seconds 0..59. Seconds wrapping from 59 to 0 advance minutes 0..59. Minutes wrapping advance hours 0..23. Hours wrapping advance the day count 0..255. Day 255 wraps to 0.
- R3: Address 0 reads and writes the time word: seconds in bits [5:0], minutes in [11:6], hours in [16:12], days in [31:17].
- R4: Event bits are: bit 0 seconds (every tick), bit 1 minutes (seconds wrap), bit 2 hours (minutes wrap), bit 3 midnight (23:59:59 to 00:00:00), bit 4 stopwatch expiry, bit 5 alarm.
- R5: Address 1 is the enable register. Bits [5:0] are read/write and the other bits read as zero.
- R6: Address 2 holds the pending flags. Each event sets its flag whatever the enable. A flag stays set until a bus write with a 1 in that bit clears it. A new event in the same cycle wins over the clear.
- R7: irq is high exactly while some pending flag has its enable bit set. wake is high for one cycle after any cycle in which an enabled event occurred.
- R8: Address 3 is the stopwatch. It decrements once per tick while nonzero, and sets event bit 4 on the tick that brings it to zero. At zero it stays at zero and raises no event.
- R9: Address 4 is the alarm. Event bit 5 is set on a tick whose resulting time word equals the alarm register.
- R10: A tick in the same cycle as a time write is dropped. The written value is loaded and no time event (bits 0 to 3) is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt: any pending and enabled flag |
| wake | output | 1 | One-cycle wake-up pulse on an enabled event |

## Verification
The hardest cases to reach from the ports are the cascaded rollovers: the hours and midnight events and the day wrap at 255. At one tick per second, these take a simulated day or more to arrive. The bench first sweeps a full day of ticks, one per clock, and compares every time word and every minute wake pulse against an arithmetic model. It then reaches the rare boundaries directly by writing times just before them, such as day 255 at 23:59:59, and applying a single tick. Coincidences are also driven on purpose: a tick in the same cycle as a time write, and an event in the same cycle as a pending clear.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int SEC_W    = 6;
    localparam int MIN_W    = 6;
    localparam int HR_W     = 5;
    localparam int DAY_W    = 15;
    localparam int SEC_LAST = 59;
    localparam int MIN_LAST = 59;
    localparam int HR_LAST  = 23;
    localparam int DAY_LAST = 255;
    localparam int NUM_EV   = 6;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;

    // event bit positions
    localparam int EV_SEC   = 0;
    localparam int EV_MIN   = 1;
    localparam int EV_HR    = 2;
    localparam int EV_DAY   = 3;
    localparam int EV_SW    = 4;
    localparam int EV_ALM   = 5;

    // register addresses
    localparam logic [ADDR_W-1:0] A_TIME  = 3'd0;
    localparam logic [ADDR_W-1:0] A_IRQEN = 3'd1;
    localparam logic [ADDR_W-1:0] A_PEND  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SWCH  = 3'd3;
    localparam logic [ADDR_W-1:0] A_ALARM = 3'd4;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } rtc_time_t;

    typedef enum logic [0:0] {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sw_state_e;
endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      adv,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t time_q,
    output rtc_time_t time_next,
    output logic      roll_sec,
    output logic      roll_min,
    output logic      roll_hr
);
    always_comb begin
        roll_sec  = (time_q.sec >= SEC_W'(SEC_LAST));
        roll_min  = roll_sec && (time_q.min >= MIN_W'(MIN_LAST));
        roll_hr   = roll_min && (time_q.hr >= HR_W'(HR_LAST));
        time_next = time_q;
        if (!roll_sec) begin
            time_next.sec = time_q.sec + 1'b1;
        end else begin
            time_next.sec = '0;
            if (!roll_min) begin
                time_next.min = time_q.min + 1'b1;
            end else begin
                time_next.min = '0;
                if (!roll_hr) begin
                    time_next.hr = time_q.hr + 1'b1;
                end else begin
                    time_next.hr  = '0;
                    time_next.day = (time_q.day >= DAY_W'(DAY_LAST)) ? '0
                                                                      : time_q.day + 1'b1;
                end
            end
        end
    end

    // time is not reset: software loads it
    always_ff @(posedge clk) begin
        if (load) begin
            time_q <= load_val;
        end else if (adv) begin
            time_q <= time_next;
        end
    end
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch
    import rtc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    sw_state_e state_q, state_d;
    logic      last_step;

    assign last_step = (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE: if (load && load_val != '0) state_d = SW_RUN;
            SW_RUN: begin
                if (load) begin
                    state_d = (load_val != '0) ? SW_RUN : SW_IDLE;
                end else if (tick && last_step) begin
                    state_d = SW_IDLE;
                end
            end
            default: state_d = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (state_q == SW_RUN && tick) begin
            count <= count - 1'b1;
        end
    end

    assign expire = (state_q == SW_RUN) && tick && !load && last_step;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev,
    input  logic              en_we,
    input  logic              pend_we,
    input  logic [NUM_EV-1:0] wdata,
    output logic [NUM_EV-1:0] en_q,
    output logic [NUM_EV-1:0] pend_q,
    output logic              irq,
    output logic              wake
);
    logic [NUM_EV-1:0] clr;

    assign clr = pend_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            wake   <= 1'b0;
        end else begin
            if (en_we) en_q <= wdata;
            pend_q <= (pend_q & ~clr) | ev;
            wake   <= |(ev & en_q);
        end
    end

    assign irq = |(pend_q & en_q);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int SW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wake
);
    rtc_time_t         time_q, time_next;
    logic              roll_sec, roll_min, roll_hr;
    logic              wr_time, wr_en, wr_pend, wr_sw, wr_alarm;
    logic              adv;
    logic [SW_W-1:0]   sw_count;
    logic              sw_expire;
    logic [DATA_W-1:0] alarm_q;
    logic [NUM_EV-1:0] ev, en_q, pend_q;

    assign wr_time  = bus_wr && bus_addr == A_TIME;
    assign wr_en    = bus_wr && bus_addr == A_IRQEN;
    assign wr_pend  = bus_wr && bus_addr == A_PEND;
    assign wr_sw    = bus_wr && bus_addr == A_SWCH;
    assign wr_alarm = bus_wr && bus_addr == A_ALARM;
    assign adv      = tick_1hz && !wr_time;

    rtc_time_counter u_time (
        .clk       (clk),
        .adv       (adv),
        .load      (wr_time),
        .load_val  (rtc_time_t'(bus_wdata)),
        .time_q    (time_q),
        .time_next (time_next),
        .roll_sec  (roll_sec),
        .roll_min  (roll_min),
        .roll_hr   (roll_hr)
    );

    rtc_stopwatch #(.CNT_W(SW_W)) u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .load     (wr_sw),
        .load_val (bus_wdata[SW_W-1:0]),
        .count    (sw_count),
        .expire   (sw_expire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '1;
        end else if (wr_alarm) begin
            alarm_q <= bus_wdata;
        end
    end

    always_comb begin
        ev         = '0;
        ev[EV_SEC] = adv;
        ev[EV_MIN] = adv && roll_sec;
        ev[EV_HR]  = adv && roll_min;
        ev[EV_DAY] = adv && roll_hr;
        ev[EV_SW]  = sw_expire;
        ev[EV_ALM] = adv && (DATA_W'(time_next) == alarm_q);
    end

    rtc_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .en_we   (wr_en),
        .pend_we (wr_pend),
        .wdata   (bus_wdata[NUM_EV-1:0]),
        .en_q    (en_q),
        .pend_q  (pend_q),
        .irq     (irq),
        .wake    (wake)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_TIME:  bus_rdata = DATA_W'(time_q);
            A_IRQEN: bus_rdata = DATA_W'(en_q);
            A_PEND:  bus_rdata = DATA_W'(pend_q);
            A_SWCH:  bus_rdata = DATA_W'(sw_count);
            A_ALARM: bus_rdata = alarm_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_pkg::*;
#(
    parameter int SW_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input rtc_time_t         time_q,
    input logic [NUM_EV-1:0] en_q,
    input logic [NUM_EV-1:0] pend_q,
    input logic [SW_W-1:0]   sw_count,
    input logic              irq
);
    logic wt, we, wp, ws;
    assign wt = bus_wr && bus_addr == A_TIME;
    assign we = bus_wr && bus_addr == A_IRQEN;
    assign wp = bus_wr && bus_addr == A_PEND;
    assign ws = bus_wr && bus_addr == A_SWCH;

    a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !wt && time_q.sec == SEC_W'(SEC_LAST)) |=> time_q.sec == '0);

    a_r2_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !wt) |=> $stable(time_q));

    a_r5_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en_q));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wp |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

    a_r8_sw_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_count == '0 && !ws) |=> sw_count == '0);

    a_r8_sw_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !ws && sw_count != '0) |=> sw_count == $past(sw_count) - SW_W'(1));
endmodule

bind rtc_core rtc_core_chk #(.SW_W(SW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .time_q   (time_q),
    .en_q     (en_q),
    .pend_q   (pend_q),
    .sw_count (sw_count),
    .irq      (irq)
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq, wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_core dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wake(wake)
    );

    function automatic logic [31:0] pack(int d, int h, int m, int s);
        return {d[14:0], h[4:0], m[5:0], s[5:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic tick1();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int s, m, h, d;
        logic exp_wake;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd1, v); chk("R1 enable", v, 0);
        rd(3'd2, v); chk("R1 pending", v, 0);
        rd(3'd3, v); chk("R1 stopwatch", v, 0);
        rd(3'd4, v); chk("R1 alarm", v, 32'hFFFF_FFFF);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 wake", {31'd0, wake}, 0);

        // R3 packing and readback
        wr(3'd0, pack(200, 17, 42, 9));
        rd(3'd0, v); chk("R3 time readback", v, pack(200, 17, 42, 9));
        chk("R3 hours field", {27'd0, v[16:12]}, 17);
        wr(3'd1, 32'hFFFF_FFC2);
        rd(3'd1, v); chk("R5 enable readback", v, 32'h02);

        // R2 / R4 full-day sweep, minute wake pulses
        wr(3'd0, pack(0, 0, 0, 0));
        s = 0; m = 0; h = 0; d = 0;
        @(negedge clk);
        tick_1hz = 1'b1; bus_addr = 3'd0;
        for (int i = 0; i < 86400; i++) begin
            @(posedge clk);
            exp_wake = 1'b0;
            s++;
            if (s == 60) begin
                s = 0; m++; exp_wake = 1'b1;
                if (m == 60) begin
                    m = 0; h++;
                    if (h == 24) begin h = 0; d = (d == 255) ? 0 : d + 1; end
                end
            end
            @(negedge clk);
            #2;
            chk("R2 sweep time", bus_rdata, pack(d, h, m, s));
            chk("R4 sweep minute wake", {31'd0, wake}, {31'd0, exp_wake});
        end
        tick_1hz = 1'b0;

        // R2 / R4 hour rollover
        wr(3'd2, 32'h3F);
        wr(3'd0, pack(5, 5, 59, 59));
        tick1();
        rd(3'd0, v); chk("R2 hour carry", v, pack(5, 6, 0, 0));
        rd(3'd2, v); chk("R4 hour events", v, 32'h07);

        // R2 / R4 midnight with day wrap
        wr(3'd2, 32'h3F);
        wr(3'd0, pack(255, 23, 59, 59));
        tick1();
        rd(3'd0, v); chk("R2 day wrap", v, pack(0, 0, 0, 0));
        rd(3'd2, v); chk("R4 midnight events", v, 32'h0F);

        // R6 write-one-to-clear and sticky
        wr(3'd2, 32'h01);
        repeat (3) @(negedge clk);
        rd(3'd2, v); chk("R6 partial clear", v, 32'h0E);

        // R7 masking and wake
        wr(3'd1, 32'h0);
        #2 chk("R7 irq masked", {31'd0, irq}, 0);
        wr(3'd1, 32'h04);
        #2 chk("R7 irq enabled", {31'd0, irq}, 1);
        wr(3'd1, 32'h01);
        tick1();
        #2 chk("R7 wake pulse", {31'd0, wake}, 1);
        @(negedge clk);
        #2 chk("R7 wake drops", {31'd0, wake}, 0);

        // R8 stopwatch
        wr(3'd2, 32'h3F);
        wr(3'd3, 32'd3);
        tick1(); tick1();
        rd(3'd3, v); chk("R8 countdown", v, 1);
        rd(3'd2, v); chk("R8 no early expiry", v & 32'h10, 0);
        tick1();
        rd(3'd3, v); chk("R8 reaches zero", v, 0);
        rd(3'd2, v); chk("R8 expiry event", v & 32'h10, 32'h10);
        wr(3'd2, 32'h10);
        tick1();
        rd(3'd3, v); chk("R8 stays zero", v, 0);
        rd(3'd2, v); chk("R8 no event at zero", v & 32'h10, 0);

        // R9 alarm
        wr(3'd0, pack(2, 10, 20, 30));
        wr(3'd4, pack(2, 10, 20, 31));
        wr(3'd2, 32'h3F);
        tick1();
        rd(3'd2, v); chk("R9 alarm match", v & 32'h20, 32'h20);
        wr(3'd2, 32'h20);
        tick1();
        rd(3'd2, v); chk("R9 no repeat", v & 32'h20, 0);

        // R10 write and tick together
        wr(3'd2, 32'h3F);
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = pack(1, 1, 1, 1); bus_wr = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_1hz = 1'b0;
        rd(3'd0, v); chk("R10 write wins", v, pack(1, 1, 1, 1));
        rd(3'd2, v); chk("R10 no time event", v, 0);

        // R6 set beats clear
        @(negedge clk);
        bus_addr = 3'd2; bus_wdata = 32'h01; bus_wr = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_1hz = 1'b0;
        rd(3'd2, v); chk("R6 set wins", v & 32'h01, 32'h01);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule